// File: doc/BRIEF.md
# Operand-Triggered Multiply-Accumulate Unit

This block is a register-mapped 16x16 multiplier with a 48-bit accumulator, sitting on a simple processor register bus. The host programs a control register to pick the operation and how many operand writes start it. It then writes the operands. The write that completes the group runs the operation and updates the product and accumulator registers at the same clock edge. No separate start command is needed.

Four operations are available: multiply, multiply-negate, multiply-accumulate and multiply-subtract. A square mode starts on a single operand write and squares the written value. Any control write rearms the operand counter, clears the sticky overflow flag and can optionally zero both operands.

The bus is a plain single-cycle register interface and has no back-pressure. A write takes effect at the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr` and is valid in the same cycle.

Register map (`bus_addr`):
- 0: control.
- 1: operand A.
- 2: operand B.
- 3: accumulator bits 15:0.
- 4: accumulator bits 31:16.
- 5: accumulator bits 47:32.
- 6: product bits 15:0.
- 7: product bits 31:16.

Control register bit fields:
- Bit 0: signed.
- Bit 1: subtract.
- Bit 2: accumulate.
- Bit 3: square.
- Bit 4: single-operand trigger.
- Bit 5: clear operands. This bit is write-only and reads as 0.
- Bit 6: overflow. This bit is read-only.

Top module: `opmac_unit`

## Requirements
- R1: After reset, every register (control, both operands, the three accumulator words and the two product words) reads 0.
- R2: With bits 4 and 3 clear, the first operand write after arming changes neither the accumulator nor the product. The second operand write, to either register, triggers the operation.
- R3: With bit 4 set and bit 3 clear, every operand write triggers the operation. The operation uses the newly written value and the current content of the other operand register.
- R4: With bit 3 set, a single write to either operand register triggers, whatever bit 4 holds. The product is the written value squared, and the other operand register keeps its value.
- R5: A control write returns the operand counter to zero. Both operands keep their values unless bit 5 is set in that write, in which case both become 0.
- R6: Plain multiply (bits 2 and 1 clear) places the product in the product register and the extended product in the accumulator. The product is signed when bit 0 is 1 and unsigned when bit 0 is 0.
- R7: Multiply-negate (bit 2 clear, bit 1 set) is always signed. The product register holds the signed product, and the accumulator holds its 48-bit negation.
- R8: Multiply-accumulate (bit 2 set, bit 1 clear) adds the extended product to the accumulator, with signedness taken from bit 0.
- R9: Multiply-subtract (bits 2 and 1 set) subtracts the extended product from the accumulator, with signedness taken from bit 0.
- R10: Control bit 6 is set when an accumulate or subtract result falls outside the 48-bit range for the chosen signedness. It stays set through later operations and is cleared by any control write.
- R11: The accumulator words are writable from the bus. Writes to the product words are ignored.
- R12: The results of a triggering write can be read in the cycle right after that write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |

## Verification
The bench sweeps twelve corner operands against each other in all seven operation and sign combinations. For the two accumulating operations it also starts from five accumulator presets at the 48-bit limits, and it compares the accumulator, the product and the overflow flag against arithmetic done in the bench.

Each class of design error shows up as a specific failure:
- A design that picks the wrong sign extension shows bad high accumulator words for operands such as 0x8000 or 0xFFFF.
- A design that applies the sign bit to negate gives unsigned results for that operation.
- A design that tests the wrong carry bit flags overflow at the wrong presets.

Directed sequences cover the counter behaviour. A control write between two operand writes must stop the pending trigger, while a design that forgets to rearm would fire early. The bench also checks that square mode fires on one write, that clearing zeroes the operands, and that writes to the product address leave the product unchanged.

// File: rtl/opmac_pkg.sv
package opmac_pkg;

  // Control register bit positions (software-visible layout)
  localparam int CB_SGN = 0;
  localparam int CB_SUB = 1;
  localparam int CB_ACC = 2;
  localparam int CB_SQR = 3;
  localparam int CB_ONE = 4;
  localparam int CB_CLR = 5;
  localparam int CB_OVF = 6;
  localparam int CTRL_BITS = 7;

  // Fixed low addresses; accumulator and product words follow
  localparam int RA_CTRL = 0;
  localparam int RA_OPA  = 1;
  localparam int RA_OPB  = 2;
  localparam int RA_ACC_BASE = 3;

  typedef enum logic [1:0] {
    OP_MUL = 2'd0,
    OP_NEG = 2'd1,
    OP_MAC = 2'd2,
    OP_MSU = 2'd3
  } op_e;

  typedef struct packed {
    logic one_op;
    logic sqr;
    logic accum;
    logic sub;
    logic sgn;
  } mode_t;

  function automatic op_e decode_op(mode_t m);
    if (m.accum) return m.sub ? OP_MSU : OP_MAC;
    return m.sub ? OP_NEG : OP_MUL;
  endfunction

endpackage

// File: rtl/opmac_trigger.sv
module opmac_trigger #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             op_wr,
  input  logic             single,
  output logic             fire,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] cnt_inc;

  assign need    = single ? CNT_W'(1) : CNT_W'(2);
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign fire    = op_wr && (cnt_inc >= need);
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (ctrl_wr) cnt_q <= '0;
    else if (fire)    cnt_q <= '0;
    else if (op_wr)   cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/opmac_arith.sv
module opmac_arith
  import opmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 48,
  localparam int PW   = 2 * OP_W
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  logic [ACC_W-1:0] acc_in,
  input  op_e              op,
  input  logic             sgn,
  output logic [PW-1:0]    prod,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf
);
  logic             eff_s;
  logic [PW-1:0]    p_s;
  logic [PW-1:0]    p_u;
  logic [ACC_W-1:0] ext;
  logic [ACC_W:0]   acc_x;
  logic [ACC_W:0]   ext_x;
  logic [ACC_W:0]   sum;

  // negate is a signed-only operation
  assign eff_s = sgn || (op == OP_NEG);
  assign p_s   = PW'($signed(a)) * PW'($signed(b));
  assign p_u   = PW'(a) * PW'(b);
  assign prod  = eff_s ? p_s : p_u;
  assign ext   = eff_s ? {{(ACC_W-PW){prod[PW-1]}}, prod}
                       : {{(ACC_W-PW){1'b0}}, prod};
  assign acc_x = eff_s ? {acc_in[ACC_W-1], acc_in} : {1'b0, acc_in};
  assign ext_x = eff_s ? {ext[ACC_W-1], ext} : {1'b0, ext};
  assign sum   = (op == OP_MSU) ? (acc_x - ext_x) : (acc_x + ext_x);

  always_comb begin
    acc_out = ext;
    ovf     = 1'b0;
    unique case (op)
      OP_MUL: acc_out = ext;
      OP_NEG: acc_out = -ext;
      OP_MAC, OP_MSU: begin
        acc_out = sum[ACC_W-1:0];
        ovf     = eff_s ? (sum[ACC_W] ^ sum[ACC_W-1]) : sum[ACC_W];
      end
      default: acc_out = ext;
    endcase
  end
endmodule

// File: rtl/opmac_readmux.sv
module opmac_readmux
  import opmac_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 48,
  parameter int ADDR_W = 3,
  localparam int PW        = 2 * OP_W,
  localparam int ACC_WORDS = ACC_W / OP_W,
  localparam int PRD_WORDS = PW / OP_W,
  localparam int PRD_BASE  = RA_ACC_BASE + ACC_WORDS
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CTRL_BITS-1:0] ctrl,
  input  logic [OP_W-1:0]      opa,
  input  logic [OP_W-1:0]      opb,
  input  logic [ACC_W-1:0]     acc,
  input  logic [PW-1:0]        prod,
  output logic [OP_W-1:0]      rdata
);
  logic [OP_W-1:0] acc_w [ACC_WORDS];
  logic [OP_W-1:0] prd_w [PRD_WORDS];

  for (genvar k = 0; k < ACC_WORDS; k++) begin : g_accw
    assign acc_w[k] = acc[k*OP_W +: OP_W];
  end
  for (genvar k = 0; k < PRD_WORDS; k++) begin : g_prdw
    assign prd_w[k] = prod[k*OP_W +: OP_W];
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(RA_CTRL)) rdata = OP_W'(ctrl);
    if (addr == ADDR_W'(RA_OPA))  rdata = opa;
    if (addr == ADDR_W'(RA_OPB))  rdata = opb;
    for (int k = 0; k < ACC_WORDS; k++)
      if (addr == ADDR_W'(RA_ACC_BASE + k)) rdata = acc_w[k];
    for (int k = 0; k < PRD_WORDS; k++)
      if (addr == ADDR_W'(PRD_BASE + k)) rdata = prd_w[k];
  end
endmodule

// File: rtl/opmac_unit.sv
module opmac_unit
  import opmac_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 48,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [OP_W-1:0]   bus_wdata,
  output logic [OP_W-1:0]   bus_rdata
);
  localparam int PW        = 2 * OP_W;
  localparam int ACC_WORDS = ACC_W / OP_W;
  localparam int CNT_W     = 2;

  mode_t            mode_q;
  logic             ovf_q;
  logic [OP_W-1:0]  opa_q, opb_q;
  logic [ACC_W-1:0] acc_q;
  logic [PW-1:0]    prod_q;

  logic             ctrl_wr, wr_a, wr_b, op_wr, fire;
  logic [CNT_W-1:0] arm_cnt;
  logic [OP_W-1:0]  a_eff, b_eff;
  logic [PW-1:0]    prod_d;
  logic [ACC_W-1:0] acc_d;
  logic             ovf_d;
  op_e              op;
  logic [CTRL_BITS-1:0] ctrl_rd;

  assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(RA_CTRL));
  assign wr_a    = bus_we && (bus_addr == ADDR_W'(RA_OPA));
  assign wr_b    = bus_we && (bus_addr == ADDR_W'(RA_OPB));
  assign op_wr   = wr_a || wr_b;
  assign op      = decode_op(mode_q);

  // square uses the written value twice; otherwise the fresh value joins the stored one
  assign a_eff = (mode_q.sqr || wr_a) ? bus_wdata : opa_q;
  assign b_eff = (mode_q.sqr || wr_b) ? bus_wdata : opb_q;

  opmac_trigger #(.CNT_W(CNT_W)) i_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_wr(ctrl_wr),
    .op_wr  (op_wr),
    .single (mode_q.sqr || mode_q.one_op),
    .fire   (fire),
    .count  (arm_cnt)
  );

  opmac_arith #(.OP_W(OP_W), .ACC_W(ACC_W)) i_arith (
    .a      (a_eff),
    .b      (b_eff),
    .acc_in (acc_q),
    .op     (op),
    .sgn    (mode_q.sgn),
    .prod   (prod_d),
    .acc_out(acc_d),
    .ovf    (ovf_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ovf_q  <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q.sgn    <= bus_wdata[CB_SGN];
      mode_q.sub    <= bus_wdata[CB_SUB];
      mode_q.accum  <= bus_wdata[CB_ACC];
      mode_q.sqr    <= bus_wdata[CB_SQR];
      mode_q.one_op <= bus_wdata[CB_ONE];
      ovf_q         <= 1'b0;
    end else if (fire && ovf_d) begin
      ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (ctrl_wr && bus_wdata[CB_CLR]) begin
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      if (wr_a) opa_q <= bus_wdata;
      if (wr_b) opb_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      prod_q <= '0;
    end else if (fire) begin
      acc_q  <= acc_d;
      prod_q <= prod_d;
    end else if (bus_we) begin
      for (int k = 0; k < ACC_WORDS; k++)
        if (bus_addr == ADDR_W'(RA_ACC_BASE + k))
          acc_q[k*OP_W +: OP_W] <= bus_wdata;
    end
  end

  assign ctrl_rd = {ovf_q, 1'b0, mode_q.one_op, mode_q.sqr,
                    mode_q.accum, mode_q.sub, mode_q.sgn};

  opmac_readmux #(.OP_W(OP_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) i_rmux (
    .addr (bus_addr),
    .ctrl (ctrl_rd),
    .opa  (opa_q),
    .opb  (opb_q),
    .acc  (acc_q),
    .prod (prod_q),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/opmac_checker.sv
module opmac_checker
  import opmac_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 48,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [OP_W-1:0]   bus_wdata,
  input logic              fire,
  input logic [1:0]        arm_cnt,
  input logic              ovf_q,
  input logic [OP_W-1:0]   opa_q,
  input logic [OP_W-1:0]   opb_q,
  input logic [ACC_W-1:0]  acc_q,
  input logic [2*OP_W-1:0] prod_q
);
  logic c_wr, o_wr;
  assign c_wr = bus_we && (bus_addr == ADDR_W'(RA_CTRL));
  assign o_wr = bus_we && ((bus_addr == ADDR_W'(RA_OPA)) || (bus_addr == ADDR_W'(RA_OPB)));

  a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr |=> (arm_cnt == 2'd0));
  a_r5_keep_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && !bus_wdata[CB_CLR]) |=> ($stable(opa_q) && $stable(opb_q)));
  a_r5_clear_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && bus_wdata[CB_CLR]) |=> (opa_q == '0 && opb_q == '0));
  a_r10_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr |=> !ovf_q);
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !c_wr) |=> ovf_q);
  a_r2_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (o_wr && !fire) |=> ($stable(acc_q) && $stable(prod_q)));
  a_r11_prod_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !fire) |=> $stable(prod_q));
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    arm_cnt <= 2'd1);
endmodule

bind opmac_unit opmac_checker #(.OP_W(OP_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .fire     (fire),
  .arm_cnt  (arm_cnt),
  .ovf_q    (ovf_q),
  .opa_q    (opa_q),
  .opb_q    (opb_q),
  .acc_q    (acc_q),
  .prod_q   (prod_q)
);

// File: tb/test_opmac_unit.sv
`timescale 1ns/1ps
module test_opmac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  opmac_unit i_opmac_unit (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_acc(output logic [47:0] v);
    logic [15:0] w0, w1, w2;
    rd(3'd3, w0); rd(3'd4, w1); rd(3'd5, w2);
    v = {w2, w1, w0};
  endtask

  task automatic rd_prod(output logic [31:0] v);
    logic [15:0] w0, w1;
    rd(3'd6, w0); rd(3'd7, w1);
    v = {w1, w0};
  endtask

  task automatic wr_acc(input logic [47:0] v);
    wr(3'd3, v[15:0]); wr(3'd4, v[31:16]); wr(3'd5, v[47:32]);
  endtask

  function automatic logic [15:0] val(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
      3: return 16'h7FFF;  4: return 16'h8000;  5: return 16'hFFFF;
      6: return 16'hFFFE;  7: return 16'h1234;  8: return 16'hA5A5;
      9: return 16'h00FF;  10: return 16'h8001; default: return 16'h7FFE;
    endcase
  endfunction

  function automatic logic [47:0] preset(input int i);
    case (i)
      0: return 48'h0;
      1: return 48'h7FFF_FFFF_FFFF;
      2: return 48'hFFFF_FFFF_FFFF;
      3: return 48'h8000_0000_0000;
      default: return 48'h0000_0000_0001;
    endcase
  endfunction

  // control codes: bit0 signed, bit1 subtract, bit2 accumulate
  function automatic logic [15:0] mode_code(input int m);
    case (m)
      0: return 16'h00; 1: return 16'h01; 2: return 16'h02;
      3: return 16'h04; 4: return 16'h05; 5: return 16'h06;
      default: return 16'h07;
    endcase
  endfunction

  function automatic string mode_req(input int m);
    case (m)
      0, 1: return "R6";
      2: return "R7";
      3, 4: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin : main
    logic [15:0] d;
    logic [47:0] acc_v;
    logic [31:0] prd_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of all eight registers
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset read", 64'(d), 64'h0);
    end

    // R11: accumulator writable, product read-only
    wr_acc(48'h3333_2222_1111);
    wr(3'd6, 16'hFFFF); wr(3'd7, 16'hEEEE);
    rd_acc(acc_v); chk("R11 acc write", 64'(acc_v), 64'h3333_2222_1111);
    rd_prod(prd_v); chk("R11 prod ignores writes", 64'(prd_v), 64'h0);

    // R2: two-operand trigger, signed multiply
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'd3);
    rd_acc(acc_v); chk("R2 first write no op", 64'(acc_v), 64'h3333_2222_1111);
    wr(3'd2, 16'd5);
    rd_acc(acc_v); chk("R2 R12 second write triggers", 64'(acc_v), 64'd15);
    rd_prod(prd_v); chk("R2 product", 64'(prd_v), 64'd15);

    // R3: single-operand trigger uses stored B
    wr(3'd0, 16'h0010);
    rd(3'd1, d); chk("R5 operand kept", 64'(d), 64'd3);
    wr(3'd1, 16'd7);
    rd_prod(prd_v); chk("R3 write A triggers", 64'(prd_v), 64'd35);
    wr(3'd2, 16'd2);
    rd_acc(acc_v); chk("R3 write B triggers", 64'(acc_v), 64'd14);

    // R4: square, count bit 0
    wr(3'd0, 16'h0008);
    wr(3'd2, 16'd9);
    rd_prod(prd_v); chk("R4 square via B", 64'(prd_v), 64'd81);
    rd(3'd1, d); chk("R4 other operand kept", 64'(d), 64'd7);
    wr(3'd1, 16'hFFFF);
    rd_prod(prd_v); chk("R4 square via A", 64'(prd_v), 64'hFFFE_0001);

    // R5: control write rearms counter
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd4);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd6);
    rd_prod(prd_v); chk("R5 rearm blocks trigger", 64'(prd_v), 64'hFFFE_0001);
    wr(3'd1, 16'd10);
    rd_prod(prd_v); chk("R5 trigger after rearm", 64'(prd_v), 64'd60);
    wr(3'd0, 16'h0020);
    rd(3'd1, d); chk("R5 clear A", 64'(d), 64'h0);
    rd(3'd2, d); chk("R5 clear B", 64'(d), 64'h0);
    rd(3'd0, d); chk("R5 clear bit reads 0", 64'(d), 64'h0);

    // R10: signed overflow, sticky, cleared by control write
    wr_acc(48'h7FFF_FFFF_FFFF);
    wr(3'd0, 16'h0015);
    wr(3'd1, 16'd5);
    wr(3'd2, 16'd1);
    rd_acc(acc_v); chk("R8 wrap", 64'(acc_v), 64'h8000_0000_0004);
    rd(3'd0, d); chk("R10 overflow set", 64'(d[6]), 64'd1);
    wr(3'd1, 16'd0);
    rd(3'd0, d); chk("R10 overflow sticky", 64'(d[6]), 64'd1);
    wr(3'd0, 16'h0015);
    rd(3'd0, d); chk("R10 overflow cleared", 64'(d), 64'h15);

    // Sweep: all modes over corner operands
    for (int m = 0; m < 7; m++) begin
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          logic [15:0] ctl, va, vb;
          logic [47:0] pre;
          longint pa, pb, pp, av, res;
          bit s, ov;
          logic [47:0] exp_acc;
          ctl = mode_code(m);
          va = val(i); vb = val(j);
          pre = preset((i + j) % 5);
          s = ctl[0] || (m == 2);
          pa = s ? longint'($signed(va)) : longint'(va);
          pb = s ? longint'($signed(vb)) : longint'(vb);
          pp = pa * pb;
          av = s ? longint'($signed(pre)) : longint'({16'h0, pre});
          ov = 1'b0;
          if (m == 0 || m == 1) res = pp;
          else if (m == 2) res = -pp;
          else begin
            res = (m >= 5) ? av - pp : av + pp;
            if (s) ov = (res > 64'sh7FFF_FFFF_FFFF) || (res < -64'sh8000_0000_0000);
            else   ov = (res < 0) || (res > 64'shFFFF_FFFF_FFFF);
          end
          exp_acc = res[47:0];
          wr_acc(pre);
          wr(3'd0, ctl);
          wr(3'd1, va);
          wr(3'd2, vb);
          rd_acc(acc_v); chk(mode_req(m), 64'(acc_v), 64'(exp_acc));
          rd_prod(prd_v); chk(mode_req(m), 64'(prd_v), 64'(pp[31:0]));
          rd(3'd0, d); chk("R10 sweep flag", 64'(d[6]), 64'(ov));
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule